// File: doc/BRIEF.md
# Recoverable Fault Collector with Test Injection

This block gathers recoverable fault strobes from five software sources and sixteen hardware sources. Each strobe sets a sticky status bit, and the bit stays set until software clears it. A registered summary output goes high while any status bit is set, so a downstream reaction unit or interrupt controller has one line to watch.

For self-test, a mode register holds a test bit. While that bit is set, the real fault inputs are shut out. Software can then write an injection register that fires emulated faults through the same latching path a real fault would take. Software sources 0 and 1 cannot be injected.

All access goes through a single-cycle 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data.

Top module: `fault_collector`

## Requirements
- R1: After synchronous reset, the status register, the mode register, the injection register and `fault_o` are all 0.
- R2: The status and injection words share one layout. Software fault k sits at data bit 31-k, hardware fault k sits at data bit k, and bits 26:16 always read 0. The mode register is at 0x00 with the test bit at bit 0, status is at 0x08 and injection is at 0x0C. Any other address reads 0.
- R3: Outside test mode, a real fault input that is high at a clock edge sets its status bit at that edge. The bit stays set after the input falls.
- R4: `fault_o` is the registered OR of all status bits. It changes one clock after the status register changes.
- R5: Writing the status register clears each bit written as 1. Bits written as 0 are left unchanged.
- R6: If a fault event and a clear of the same bit happen in the same cycle, the bit stays set.
- R7: While the test bit is set, real fault inputs set no status bit.
- R8: In test mode, writing 1 to an injection bit (from software source 2 upward, or any hardware source) produces a one-cycle event. That event sets the matching status bit one clock after the write. The injection bit then reads back as 0.
- R9: Injection bits for software sources 0 and 1 (data bits 31 and 30) have no effect.
- R10: Outside test mode, writes to the injection register are ignored and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| sw_fault_i | input | 5 | Software recoverable fault strobes, bit k = source k |
| hw_fault_i | input | 16 | Hardware recoverable fault strobes, bit k = source k |
| fault_o | output | 1 | High while any status bit is set |

## Verification
The bench builds the block with its package defaults: five software sources, sixteen hardware sources and two non-injectable software sources. With these values, the unused gap between the two fields (bits 26:16) can be checked for zeros. The two locked software positions sit at the top of the word, so an all-ones injection must come back as 0x3800FFFF.

The defaults also let a single all-ones strobe on every input check the complete layout in one read. The same-cycle race between set and clear is driven on a hardware bit, and the one-cycle delay of `fault_o` is sampled on both edges of the status change.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 4;
    localparam int NUM_SW        = 5;
    localparam int NUM_HW        = 16;
    localparam int NUM_LOCKED_SW = 2;

    typedef struct packed {
        logic [NUM_SW-1:0] sw;
        logic [NUM_HW-1:0] hw;
    } fault_vec_t;

    typedef enum logic [1:0] {SEL_MODE, SEL_STAT, SEL_FAKE, SEL_NONE} reg_sel_e;

    localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4'h8);
    localparam logic [ADDR_W-1:0] OFS_FAKE = ADDR_W'(4'hC);

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == OFS_MODE)      return SEL_MODE;
        else if (a == OFS_STAT) return SEL_STAT;
        else if (a == OFS_FAKE) return SEL_FAKE;
        else                    return SEL_NONE;
    endfunction

    // software source k lives at the top of the word, counted downward
    function automatic logic [DATA_W-1:0] vec_to_word(input fault_vec_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int k = 0; k < NUM_SW; k++) w[DATA_W-1-k] = v.sw[k];
        w[NUM_HW-1:0] = v.hw;
        return w;
    endfunction

    function automatic fault_vec_t word_to_vec(input logic [DATA_W-1:0] w);
        fault_vec_t v;
        for (int k = 0; k < NUM_SW; k++) v.sw[k] = w[DATA_W-1-k];
        v.hw = w[NUM_HW-1:0];
        return v;
    endfunction

    function automatic fault_vec_t inject_mask();
        fault_vec_t m;
        m.hw = '1;
        for (int k = 0; k < NUM_SW; k++) m.sw[k] = (k >= NUM_LOCKED_SW);
        return m;
    endfunction
endpackage

// File: rtl/fc_regif.sv
module fc_regif
    import fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  fault_vec_t        stat_q,
    output logic              test_mode,
    output fault_vec_t        fake_q,
    output fault_vec_t        clr_vec,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_e sel;
    assign sel = decode(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            test_mode <= 1'b0;
            fake_q    <= '0;
        end else begin
            if (we && sel == SEL_MODE) test_mode <= wdata[0];
            if (we && sel == SEL_FAKE && test_mode)
                fake_q <= word_to_vec(wdata) & inject_mask();
            else
                fake_q <= '0;
        end
    end

    assign clr_vec = (we && sel == SEL_STAT) ? word_to_vec(wdata) : '0;

    always_comb begin
        unique case (sel)
            SEL_MODE: rdata = {{(DATA_W-1){1'b0}}, test_mode};
            SEL_STAT: rdata = vec_to_word(stat_q);
            SEL_FAKE: rdata = test_mode ? vec_to_word(fake_q) : '0;
            default:  rdata = '0;
        endcase
    end

    // R10
    fake_read_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && addr == OFS_FAKE) |-> rdata == '0);
    // R2
    gap_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-NUM_SW-1:NUM_HW] == '0);
endmodule

// File: rtl/fc_latch.sv
module fc_latch
    import fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_vec_t ev,
    input  fault_vec_t clr,
    output fault_vec_t stat_q
);
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr) | ev;
    end

    // R3
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));
    // R5
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr != '0) |=> ((stat_q & $past(clr & ~ev)) == '0));
endmodule

// File: rtl/fault_collector.sv
module fault_collector
    import fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SW-1:0] sw_fault_i,
    input  logic [NUM_HW-1:0] hw_fault_i,
    output logic              fault_o
);
    logic       test_mode;
    fault_vec_t fake_q, clr_vec, stat_q, real_vec, ev;

    assign real_vec.sw = sw_fault_i;
    assign real_vec.hw = hw_fault_i;
    assign ev = test_mode ? fake_q : real_vec;

    fc_regif u_regif (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .stat_q(stat_q), .test_mode(test_mode), .fake_q(fake_q),
        .clr_vec(clr_vec), .rdata(bus_rdata)
    );

    fc_latch u_latch (
        .clk(clk), .rst(rst), .ev(ev), .clr(clr_vec), .stat_q(stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) fault_o <= 1'b0;
        else     fault_o <= |stat_q;
    end

    // R4
    fault_out_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> fault_o == (|$past(stat_q)));
    // R7
    real_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (test_mode && fake_q == '0) |=> ((stat_q & ~$past(stat_q)) == '0));
    // R9
    locked_sw_chk: assert property (@(posedge clk) disable iff (rst)
        test_mode |=> !$rose(stat_q.sw[0]) && !$rose(stat_q.sw[1]));
endmodule

// File: tb/tb_fault_collector.sv
module tb_fault_collector;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [4:0]  sw_fault_i;
    logic [15:0] hw_fault_i;
    logic        fault_o;
    int total = 0;
    int bad = 0;
    bit done = 0;

    fault_collector dut (.*);

    always #10 clk = ~clk;

    function automatic logic [31:0] swb(input int k);
        return 32'h1 << (31 - k);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] s, input logic [15:0] h);
        @(negedge clk);
        sw_fault_i = s; hw_fault_i = h;
        @(negedge clk);
        sw_fault_i = '0; hw_fault_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h0, d); check("R1 mode", d, 0);
        rd(4'h8, d); check("R1 status", d, 0);
        check("R1 fault_o", {31'b0, fault_o}, 0);
    endtask

    task automatic t_real();
        logic [31:0] d;
        pulse(5'b00100, 16'h0008);
        rd(4'h8, d); check("R3 R2 status", d, swb(2) | 32'h8);
        check("R4 fault_o lag", {31'b0, fault_o}, 0);
        @(negedge clk);
        check("R4 fault_o rise", {31'b0, fault_o}, 1);
        rd(4'h8, d); check("R3 sticky", d, swb(2) | 32'h8);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        pulse(5'h1F, 16'hFFFF);
        rd(4'h8, d); check("R2 full layout", d, 32'hF800FFFF);
        rd(4'h4, d); check("R2 unmapped", d, 0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(4'h8, 32'h0);
        rd(4'h8, d); check("R5 zero write", d, 32'hF800FFFF);
        wr(4'h8, swb(0) | 32'h1);
        rd(4'h8, d); check("R5 partial clear", d, 32'h7800FFFE);
        wr(4'h8, 32'hFFFFFFFF);
        rd(4'h8, d); check("R5 full clear", d, 0);
        check("R4 fault_o still high", {31'b0, fault_o}, 1);
        @(negedge clk);
        check("R4 fault_o fall", {31'b0, fault_o}, 0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        pulse(5'b0, 16'h0020);
        @(negedge clk);
        bus_addr = 4'h8; bus_we = 1'b1; bus_wdata = 32'h20; hw_fault_i = 16'h0020;
        @(negedge clk);
        bus_we = 1'b0; hw_fault_i = '0;
        rd(4'h8, d); check("R6 set wins", d, 32'h20);
        wr(4'h8, 32'h20);
        rd(4'h8, d); check("R6 later clear", d, 0);
    endtask

    task automatic t_test_mode();
        logic [31:0] d;
        wr(4'h0, 32'h1);
        rd(4'h0, d); check("R2 mode bit", d, 1);
        pulse(5'h1F, 16'hFFFF);
        @(negedge clk);
        rd(4'h8, d); check("R7 real ignored", d, 0);
    endtask

    task automatic t_fake();
        logic [31:0] d;
        wr(4'hC, swb(0) | swb(1));
        @(negedge clk);
        rd(4'h8, d); check("R9 locked sources", d, 0);
        wr(4'hC, 32'hFFFFFFFF);
        rd(4'h8, d); check("R8 not yet latched", d, 0);
        @(negedge clk);
        rd(4'h8, d); check("R8 R9 injected", d, 32'h3800FFFF);
        rd(4'hC, d); check("R8 self clear", d, 0);
        @(negedge clk);
        check("R8 fault_o", {31'b0, fault_o}, 1);
        wr(4'h8, 32'hFFFFFFFF);
    endtask

    task automatic t_outside();
        logic [31:0] d;
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0000FFFF);
        @(negedge clk);
        @(negedge clk);
        rd(4'h8, d); check("R10 write ignored", d, 0);
        rd(4'hC, d); check("R10 read zero", d, 0);
        pulse(5'b10000, 16'h0);
        rd(4'h8, d); check("R3 after test exit", d, swb(4));
    endtask

    initial begin
        #4000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        sw_fault_i = '0; hw_fault_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_real();
        t_layout();
        t_clear();
        t_priority();
        t_test_mode();
        t_fake();
        t_outside();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule